// File: doc/BRIEF.md
# Multi-Format Audio Serial Frame Transmitter

This block drives the transmit side of an audio serial port as bit-clock and frame-sync master. It divides the system clock into a bit clock and marks each bit boundary with a one-cycle enable. It builds frames of a programmable length that hold two or more equal-width slots, and shifts one sample per enabled slot onto a serial data line. A five-way format selector sets three timing values: the delay from frame start to the first data bit, the length of the frame sync, and whether the frame begins on a rising or a falling sync edge. Two separate inversion bits then flip the physical bit clock and the physical frame sync.

The configuration is static. It is captured in one cycle by a load strobe, checked for consistency, and the first frame starts at once. An inconsistent set of values raises a sticky error flag and holds every serial output low until a consistent set is loaded. Samples arrive on a valid/ready handshake, one per enabled slot, at the moment that slot begins. A slot whose sample is missing is sent as zeros and reported on a one-cycle underrun pulse.

Top module: `aud_frame_tx`

## Requirements
- R1: Format code 0 (I2S): with frame inversion off, the frame sync is low for bits 0 to F/2-1 and high for the rest of the frame, where F is the frame length. The frame therefore begins on a falling sync edge, and the first data bit of each half sits at bit 1 of that half.
- R2: Format code 1 (left-justified): with frame inversion off, the frame sync is high for bits 0 to F/2-1. Data starts at bit 0 of each half.
- R3: Format code 2 (right-justified): the frame sync behaves as in R2, and the data delay equals slot width minus data length. A frame length that is odd is rejected as invalid.
- R4: Format codes 3 and 4 (DSP A and DSP B): with frame inversion off, the frame sync is high only during frame bit 0. Slots run back to back from a delay of 1 bit (code 3) or 0 bits (code 4).
- R5: In codes 0 to 2, the slot count must be even, or the configuration is rejected. Slots 0 to N/2-1 fill the first half of the frame and slots N/2 to N-1 fill the second half. Each half starts its own data delay at its own first bit.
- R6: The physical frame sync equals the logical sync (high during the sync interval) XOR the falling-start flag (set only for code 0) XOR the frame-inversion input.
- R7: Each bit lasts 2*BCLK_HALF system cycles. The bit clock is low in the first half of a bit and high in the second half, and data and frame sync change only at the start of a bit. Bit-clock inversion flips the bit clock, so that a receiver samples on the falling edge instead of the rising edge.
- R8: The configuration is invalid when any of these holds: the format code is above 4, slot count is 0 or above MAX_SLOTS, slot width is 0, data length is 0, data length exceeds the slot width, data length exceeds DATA_W, or the frame length minus one field is 0. An invalid configuration sets a sticky error flag, drives fsync, sdata and bclk to 0, and deasserts ready. The next valid load clears the flag.
- R9: Each sample is sent MSB first, starting from bit data_len-1 of the input word. Slot bit positions at or beyond the data length are sent as 0.
- R10: Bit g of the slot mask enables global slot g. A disabled slot is sent as zeros and takes no sample.
- R11: When an enabled slot begins and no sample is valid, that slot is sent as zeros and underrun is high for exactly the one cycle in which the slot's first bit appears.
- R12: If a load is sampled on clock edge E, frame bit 0 appears on the outputs at edge E+1, with bclk_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture and check the configuration inputs |
| cfg_format | input | 3 | Format code 0..4 |
| cfg_bclk_inv | input | 1 | Invert the physical bit clock |
| cfg_fs_inv | input | 1 | Invert the physical frame sync |
| cfg_slots | input | SC_W | Number of slots per frame |
| cfg_slot_width | input | SW_W | Bits per slot |
| cfg_data_len | input | SW_W | Significant sample bits per slot |
| cfg_frame_len_m1 | input | FL_W | Frame length in bits minus one |
| cfg_slot_mask | input | MAX_SLOTS | Per-slot enable |
| smp_data | input | DATA_W | Sample, right-aligned |
| smp_valid | input | 1 | Sample available |
| smp_ready | output | 1 | Sample taken in this cycle |
| bclk | output | 1 | Physical bit clock |
| bclk_en | output | 1 | One-cycle pulse at each bit start |
| fsync | output | 1 | Physical frame sync |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Enabled slot began without a sample |
| cfg_error | output | 1 | Sticky invalid-configuration flag |

## Verification
Every serial result for a bit comes from the same registered stage. A load sampled at edge E puts frame bit 0 on the outputs at E+1, and bit k appears 2*BCLK_HALF*k cycles after that. The bench keys every comparison to the falling clock edge right after each bclk_en pulse, and checks the second-half bit clock BCLK_HALF cycles later. Error flags are due one edge after the load, and the idle outputs are checked over the following cycles. The underrun pulse is compared at the same sampling point as the slot's first bit. The number of samples taken is compared once each run ends.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [2:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;
endpackage

// File: rtl/aud_tx_cfg.sv
module aud_tx_cfg
  import aud_tx_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int DATA_W    = 16,
  parameter int FL_W      = 9,
  parameter int SW_W      = 6,
  parameter int SC_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [2:0]           fmt_i,
  input  logic                 invb_i,
  input  logic                 invf_i,
  input  logic [SC_W-1:0]      slots_i,
  input  logic [SW_W-1:0]      sw_i,
  input  logic [SW_W-1:0]      dl_i,
  input  logic [FL_W-1:0]      flm1_i,
  input  logic [MAX_SLOTS-1:0] mask_i,
  output logic                 ok,
  output logic                 err,
  output logic                 r_two,
  output logic                 r_fall,
  output logic                 r_invb,
  output logic                 r_invf,
  output logic [SW_W-1:0]      r_dly,
  output logic [SC_W-1:0]      r_spp,
  output logic [SW_W-1:0]      r_sw,
  output logic [SW_W-1:0]      r_dl,
  output logic [FL_W-1:0]      r_flm1,
  output logic [FL_W-1:0]      r_half,
  output logic [MAX_SLOTS-1:0] r_mask
);
  logic            two, fall, fmt_ok, good;
  logic [SW_W-1:0] dly;
  logic [FL_W:0]   fl_n;

  always_comb begin
    two    = 1'b0;
    fall   = 1'b0;
    dly    = '0;
    fmt_ok = 1'b1;
    case (fmt_e'(fmt_i))
      FMT_I2S:  begin two = 1'b1; fall = 1'b1; dly = SW_W'(1); end
      FMT_LJ:   two = 1'b1;
      FMT_RJ:   begin two = 1'b1; dly = sw_i - dl_i; end
      FMT_DSPA: dly = SW_W'(1);
      FMT_DSPB: dly = '0;
      default:  fmt_ok = 1'b0;
    endcase
    fl_n = {1'b0, flm1_i} + 1'b1;
    good = fmt_ok && (slots_i != '0) && (slots_i <= SC_W'(MAX_SLOTS)) &&
           (sw_i != '0) && (dl_i != '0) && (dl_i <= sw_i) &&
           (dl_i <= SW_W'(DATA_W)) && (flm1_i != '0) &&
           !(two && slots_i[0]) &&
           !((fmt_i == 3'(FMT_RJ)) && fl_n[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok <= 1'b0; err <= 1'b0; r_two <= 1'b0; r_fall <= 1'b0;
      r_invb <= 1'b0; r_invf <= 1'b0; r_dly <= '0; r_spp <= '0;
      r_sw <= '0; r_dl <= '0; r_flm1 <= '0; r_half <= '0; r_mask <= '0;
    end else if (load) begin
      ok     <= good;
      err    <= !good;
      r_two  <= two;
      r_fall <= fall;
      r_invb <= invb_i;
      r_invf <= invf_i;
      r_dly  <= dly;
      r_spp  <= two ? (slots_i >> 1) : slots_i;
      r_sw   <= sw_i;
      r_dl   <= dl_i;
      r_flm1 <= flm1_i;
      r_half <= fl_n[FL_W:1];
      r_mask <= mask_i;
    end
  end

  // R8: the error flag holds until the next load
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (err && !load) |=> err);
  // R8: running and error are exclusive
  assert_ok_excl_R8: assert property (@(posedge clk) disable iff (rst)
    ok |-> !err);
endmodule

// File: rtl/aud_tx_bclk.sv
module aud_tx_bclk #(
  parameter int BCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic inv,
  output logic tick,
  output logic bclk,
  output logic bclk_en
);
  localparam int PER = 2 * BCLK_HALF;
  localparam int CW  = $clog2(PER);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);

  logic [CW-1:0] cnt, cnt_n;

  assign tick  = run && (cnt == LAST);
  assign cnt_n = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt     <= LAST;
      bclk    <= 1'b0;
      bclk_en <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      bclk    <= (cnt_n >= CW'(BCLK_HALF)) ^ inv;
      bclk_en <= (cnt_n == '0);
    end
  end

  // R7: bit starts are at least two cycles apart
  assert_en_gap_R7: assert property (@(posedge clk) disable iff (rst)
    bclk_en |=> !bclk_en);
  // R8: the bit clock stays low while idle
  assert_bclk_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !run |-> !bclk);
endmodule

// File: rtl/aud_tx_slot.sv
module aud_tx_slot #(
  parameter int MAX_SLOTS = 8,
  parameter int DATA_W    = 16,
  parameter int FL_W      = 9,
  parameter int SW_W      = 6,
  parameter int SC_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 r_two,
  input  logic                 r_fall,
  input  logic                 r_invf,
  input  logic [SW_W-1:0]      r_dly,
  input  logic [SC_W-1:0]      r_spp,
  input  logic [SW_W-1:0]      r_sw,
  input  logic [SW_W-1:0]      r_dl,
  input  logic [FL_W-1:0]      r_flm1,
  input  logic [FL_W-1:0]      r_half,
  input  logic [MAX_SLOTS-1:0] r_mask,
  input  logic [DATA_W-1:0]    s_data,
  input  logic                 s_valid,
  output logic                 s_ready,
  output logic                 fs_q,
  output logic                 sd_q,
  output logic                 under_q
);
  localparam int MW = 1 << SC_W;

  logic [FL_W-1:0]   fbit, nb, pb;
  logic              fresh, dact, live;
  logic [SW_W-1:0]   sbit, n_sbit, shamt;
  logic [SC_W-1:0]   sidx, n_sidx, gslot;
  logic [DATA_W-1:0] samp, src, shifted;
  logic [MW-1:0]     mask_x;
  logic              ph, n_dact, start, load_slot, take, live_n, sd_n, act, fs_n;

  assign mask_x  = MW'(r_mask);
  assign s_ready = load_slot;

  always_comb begin
    nb     = (fresh || fbit == r_flm1) ? '0 : fbit + 1'b1;
    ph     = r_two && (nb >= r_half);
    pb     = ph ? nb - r_half : nb;
    n_dact = dact;
    n_sbit = sbit;
    n_sidx = sidx;
    start  = 1'b0;
    if (pb == FL_W'(r_dly)) begin
      n_dact = 1'b1; n_sbit = '0; n_sidx = '0; start = 1'b1;
    end else if (pb == '0) begin
      n_dact = 1'b0;
    end else if (dact) begin
      if (sbit == r_sw - 1'b1) begin
        n_sbit = '0;
        if (sidx == r_spp - 1'b1) n_dact = 1'b0;
        else begin n_sidx = sidx + 1'b1; start = 1'b1; end
      end else begin
        n_sbit = sbit + 1'b1;
      end
    end
    gslot     = ph ? r_spp + n_sidx : n_sidx;
    load_slot = tick && start && mask_x[gslot];
    take      = load_slot && s_valid;
    live_n    = start ? take : live;
    src       = start ? s_data : samp;
    shamt     = r_dl - 1'b1 - n_sbit;
    shifted   = src >> shamt;
    sd_n      = n_dact && live_n && (n_sbit < r_dl) && shifted[0];
    act       = r_two ? (nb < r_half) : (nb == '0);
    fs_n      = act ^ r_fall ^ r_invf;
  end

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      fbit <= '0; fresh <= 1'b1; dact <= 1'b0; sbit <= '0; sidx <= '0;
      live <= 1'b0; samp <= '0; fs_q <= 1'b0; sd_q <= 1'b0; under_q <= 1'b0;
    end else begin
      under_q <= 1'b0;
      if (tick) begin
        fresh   <= 1'b0;
        fbit    <= nb;
        dact    <= n_dact;
        sbit    <= n_sbit;
        sidx    <= n_sidx;
        live    <= live_n;
        fs_q    <= fs_n;
        sd_q    <= sd_n;
        under_q <= load_slot && !s_valid;
        if (take) samp <= s_data;
      end
    end
  end

  // R8: serial outputs idle while not running
  assert_idle_out_R8: assert property (@(posedge clk) disable iff (rst)
    !run |-> (!fs_q && !sd_q));
  // R7: data moves only at a bit start or on restart/idle
  assert_sd_bitedge_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_q) |-> $past(tick || restart || !run));
  // R7: frame sync moves only at a bit start or on restart/idle
  assert_fs_bitedge_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(fs_q) |-> $past(tick || restart || !run));
  // R11: an underrun follows an unanswered slot request
  assert_under_cause_R11: assert property (@(posedge clk) disable iff (rst)
    under_q |-> $past(s_ready && !s_valid));
endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx #(
  parameter int MAX_SLOTS = 8,
  parameter int SW_MAX    = 32,
  parameter int DATA_W    = 16,
  parameter int FL_W      = 9,
  parameter int BCLK_HALF = 2,
  localparam int SW_W     = $clog2(SW_MAX + 1),
  localparam int SC_W     = $clog2(MAX_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_load,
  input  logic [2:0]           cfg_format,
  input  logic                 cfg_bclk_inv,
  input  logic                 cfg_fs_inv,
  input  logic [SC_W-1:0]      cfg_slots,
  input  logic [SW_W-1:0]      cfg_slot_width,
  input  logic [SW_W-1:0]      cfg_data_len,
  input  logic [FL_W-1:0]      cfg_frame_len_m1,
  input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
  input  logic [DATA_W-1:0]    smp_data,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  output logic                 bclk,
  output logic                 bclk_en,
  output logic                 fsync,
  output logic                 sdata,
  output logic                 underrun,
  output logic                 cfg_error
);
  logic                 ok, two, fall, invb, invf, tick;
  logic [SW_W-1:0]      dly, sw, dl;
  logic [SC_W-1:0]      spp;
  logic [FL_W-1:0]      flm1, half;
  logic [MAX_SLOTS-1:0] mask;

  aud_tx_cfg #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W), .FL_W(FL_W),
               .SW_W(SW_W), .SC_W(SC_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load), .fmt_i(cfg_format),
    .invb_i(cfg_bclk_inv), .invf_i(cfg_fs_inv), .slots_i(cfg_slots),
    .sw_i(cfg_slot_width), .dl_i(cfg_data_len), .flm1_i(cfg_frame_len_m1),
    .mask_i(cfg_slot_mask), .ok(ok), .err(cfg_error), .r_two(two),
    .r_fall(fall), .r_invb(invb), .r_invf(invf), .r_dly(dly), .r_spp(spp),
    .r_sw(sw), .r_dl(dl), .r_flm1(flm1), .r_half(half), .r_mask(mask)
  );

  aud_tx_bclk #(.BCLK_HALF(BCLK_HALF)) u_bclk (
    .clk(clk), .rst(rst), .restart(cfg_load), .run(ok), .inv(invb),
    .tick(tick), .bclk(bclk), .bclk_en(bclk_en)
  );

  aud_tx_slot #(.MAX_SLOTS(MAX_SLOTS), .DATA_W(DATA_W), .FL_W(FL_W),
                .SW_W(SW_W), .SC_W(SC_W)) u_slot (
    .clk(clk), .rst(rst), .restart(cfg_load), .run(ok), .tick(tick),
    .r_two(two), .r_fall(fall), .r_invf(invf), .r_dly(dly), .r_spp(spp),
    .r_sw(sw), .r_dl(dl), .r_flm1(flm1), .r_half(half), .r_mask(mask),
    .s_data(smp_data), .s_valid(smp_valid), .s_ready(smp_ready),
    .fs_q(fsync), .sd_q(sdata), .under_q(underrun)
  );
endmodule

// File: tb/aud_frame_tx_tb.sv
module aud_frame_tx_tb;
  localparam int MS   = 8;
  localparam int DW   = 16;
  localparam int FLW  = 9;
  localparam int HALF = 1;
  localparam int SWW  = 6;
  localparam int SCW  = 4;

  logic clk = 0, rst = 1;
  logic cfg_load = 0, cfg_bclk_inv = 0, cfg_fs_inv = 0;
  logic [2:0] cfg_format = 0;
  logic [SCW-1:0] cfg_slots = 0;
  logic [SWW-1:0] cfg_slot_width = 0, cfg_data_len = 0;
  logic [FLW-1:0] cfg_frame_len_m1 = 0;
  logic [MS-1:0] cfg_slot_mask = 0;
  logic [DW-1:0] smp_data;
  logic smp_valid = 0;
  logic smp_ready, bclk, bclk_en, fsync, sdata, underrun, cfg_error;

  int nvec = 0, nbad = 0, kacc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aud_frame_tx #(.MAX_SLOTS(MS), .SW_MAX(32), .DATA_W(DW), .FL_W(FLW),
                 .BCLK_HALF(HALF)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_format(cfg_format),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_fs_inv(cfg_fs_inv), .cfg_slots(cfg_slots),
    .cfg_slot_width(cfg_slot_width), .cfg_data_len(cfg_data_len),
    .cfg_frame_len_m1(cfg_frame_len_m1), .cfg_slot_mask(cfg_slot_mask),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .bclk(bclk), .bclk_en(bclk_en), .fsync(fsync), .sdata(sdata),
    .underrun(underrun), .cfg_error(cfg_error)
  );

  function automatic logic [DW-1:0] smp_val(int k);
    return DW'(k * 40503 + 4660);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  endtask

  // sample provider: advances after each accepted handshake
  initial begin
    smp_data = smp_val(0);
    forever begin
      bit hs;
      @(negedge clk);
      hs = smp_ready && smp_valid;
      @(posedge clk);
      #1;
      if (hs) begin
        kacc++;
        smp_data = smp_val(kacc);
      end
    end
  end

  task automatic load(int fmt, int slots, int sw, int dl, int flm1, int mask,
                      int ib, int ifs);
    @(negedge clk);
    cfg_format = 3'(fmt); cfg_slots = SCW'(slots); cfg_slot_width = SWW'(sw);
    cfg_data_len = SWW'(dl); cfg_frame_len_m1 = FLW'(flm1);
    cfg_slot_mask = MS'(mask); cfg_bclk_inv = ib[0]; cfg_fs_inv = ifs[0];
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic run_frames(int fmt, int slots, int sw, int dl, int flm1,
                            int mask, int ib, int ifs, int nfr, bit vld,
                            string gtag);
    int fl, half, dly, spp, kexp, kbase;
    bit two, fall, have;
    logic [DW-1:0] cur;
    string ftag;
    fl = flm1 + 1; half = fl / 2;
    two = (fmt <= 2); fall = (fmt == 0);
    dly = (fmt == 0 || fmt == 3) ? 1 : (fmt == 2) ? sw - dl : 0;
    spp = two ? slots / 2 : slots;
    ftag = (fmt == 0) ? "R1" : (fmt == 1) ? "R2" : (fmt == 2) ? "R3" : "R4";
    smp_valid = vld;
    load(fmt, slots, sw, dl, flm1, mask, ib, ifs);
    kbase = kacc; kexp = kacc; have = 0; cur = '0;
    chk("R8 error clear on valid load", 32'(cfg_error), 0);
    for (int f = 0; f < nfr; f++) begin
      for (int nb = 0; nb < fl; nb++) begin
        bit ph, act, efs, es, eu;
        int pb, off;
        ph = two && (nb >= half);
        pb = ph ? nb - half : nb;
        off = pb - dly;
        es = 0; eu = 0;
        if (pb == 0) have = 0;
        if (off >= 0 && off / sw < spp) begin
          int si, sb, g;
          si = off / sw; sb = off % sw; g = ph ? spp + si : si;
          if (sb == 0) begin
            have = 0;
            if ((mask >> g) & 1) begin
              if (vld) begin cur = smp_val(kexp); kexp++; have = 1; end
              else eu = 1;
            end
          end
          if (have && sb < dl) es = cur[dl - 1 - sb];
        end else if (off >= 0) begin
          have = 0;
        end
        act = two ? (nb < half) : (nb == 0);
        efs = act ^ fall ^ ifs[0];
        @(negedge clk);
        chk((f == 0 && nb == 0) ? "R12 first bit enable" : "R7 bit enable",
            32'(bclk_en), 1);
        chk("R7 bclk first half", 32'(bclk), 32'(ib[0]));
        chk(ifs[0] ? {ftag, " R6 fsync"} : {ftag, " fsync"}, 32'(fsync), 32'(efs));
        chk({ftag, " ", gtag, " R9 sdata"}, 32'(sdata), 32'(es));
        chk("R11 underrun", 32'(underrun), 32'(eu));
        repeat (HALF) @(negedge clk);
        chk("R7 bclk second half", 32'(bclk), 32'(!ib[0]));
        repeat (HALF - 1) @(negedge clk);
      end
    end
    chk("R10 samples consumed", 32'(kacc - kbase), 32'(kexp - kbase));
  endtask

  task automatic bad_cfg(int fmt, int slots, int sw, int dl, int flm1, string tag);
    load(fmt, slots, sw, dl, flm1, 3, 0, 1);
    chk({tag, " error raised"}, 32'(cfg_error), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 idle fsync", 32'(fsync), 0);
      chk("R8 idle sdata", 32'(sdata), 0);
      chk("R8 idle bclk", 32'(bclk), 0);
      chk("R8 idle ready", 32'(smp_ready), 0);
    end
    chk("R8 error sticky", 32'(cfg_error), 1);
  endtask

  initial begin
    #400000;
    nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset error", 32'(cfg_error), 0);
    chk("R8 reset fsync", 32'(fsync), 0);
    chk("R8 reset sdata", 32'(sdata), 0);
    chk("R8 reset bclk", 32'(bclk), 0);
    chk("R8 reset ready", 32'(smp_ready), 0);
    for (int fmt = 0; fmt < 5; fmt++) begin
      for (int inv = 0; inv < 4; inv++) begin
        run_frames(fmt, 2, 8, 6, 15, 3, inv & 1, inv >> 1, 2, 1, "stereo");
        run_frames(fmt, 4, 4, 3, 19, 11, inv & 1, inv >> 1, 2, 1, "R5 R10 tdm");
      end
    end
    run_frames(2, 2, 8, 8, 15, 3, 0, 0, 2, 1, "R3 full width");
    run_frames(0, 2, 8, 6, 15, 3, 0, 0, 1, 0, "R11 starved");
    run_frames(4, 4, 4, 3, 19, 15, 1, 0, 1, 0, "R11 starved");
    bad_cfg(2, 2, 8, 6, 16, "R3 odd frame");
    bad_cfg(1, 3, 8, 6, 23, "R5 odd slots");
    bad_cfg(3, 2, 8, 9, 15, "R8 data over slot");
    bad_cfg(5, 2, 8, 6, 15, "R8 bad format");
    run_frames(3, 4, 4, 3, 19, 11, 0, 0, 1, 1, "R8 recovery");
    finish_run();
  end
endmodule